// File: doc/BRIEF.md
# SDRAM Burst Data Pipeline

This block is the column-side data path of a single-data-rate synchronous DRAM device model. It takes decoded column commands (read, write, burst stop) together with a start column. It expands each command into a burst of column addresses. Write data goes into a small on-chip register array that stands in for the memory core. Read data comes back out of that array after the programmed CAS latency. Row activation, refresh and analog output timing are not part of it.

The burst length, the burst order, the CAS latency and a single-beat write option are set through static configuration inputs. These inputs are held stable while a burst or read data is in flight. Each byte lane has its own mask bit, and that bit acts on the two paths at different times. On a write it blocks the data sampled on the same edge. On a read it turns the lane off for the beat that appears two cycles later. A per-lane output-enable lets a test environment model the tri-state data bus.

Cycle numbering: a command is sampled at rising edge E0. Cycle k is the interval between edges E(k-1) and E(k).

Top module: `sdr_burst_path`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, `rd_oe` is all zero and `rdata` is zero.
- R2: `cfg_cas3`=0 selects latency 2 and `cfg_cas3`=1 selects latency 3. The first read beat of a read command sampled at E0 is presented in cycle 2 or cycle 3 respectively.
- R3: `cfg_blen` code n gives 2^n beats (codes 0..3 give 1, 2, 4, 8). Read beats appear in consecutive cycles, and `rd_oe` drops after the last beat.
- R4: With `cfg_ilv`=0, beat i of a burst starting at column s addresses the aligned block of the burst size that contains s, at offset (s+i) mod BL, so the order wraps inside that block.
- R5: With `cfg_ilv`=1, beat i addresses column s XOR i.
- R6: On every write beat, lane l of `wdata` (bits 8l+7..8l) is stored only if `dqm[l]` is low at the same rising edge. A masked lane keeps its old content.
- R7: If `dqm[l]` is high at edge Em, lane l is off during cycle m+2: `rd_oe[l]` is 0 and that lane of `rdata` is 0.
- R8: A read (`cmd_op`=1) or write (`cmd_op`=2) may be issued on any edge, including during a burst. It starts a new burst at once. The old burst issues no further beats, although read beats issued before that edge still appear.
- R9: A burst stop (`cmd_op`=3) ends the current burst for any burst length. No beat is issued at that edge or after it. `cmd_op`=0 is a no-operation.
- R10: With `cfg_single_wr`=1, each write command stores only its start column, while reads still use the programmed burst length.
- R11: `rd_oe` is all zero, and `rdata` is zero, in every cycle where no read beat is scheduled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; every input is sampled on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cmd_op | input | 2 | Column command: 0 none, 1 read, 2 write, 3 burst stop |
| cmd_col | input | COL_W | Start column of a read or write |
| cfg_cas3 | input | 1 | Read latency select: 0 gives 2 cycles, 1 gives 3 cycles |
| cfg_blen | input | 2 | Burst length code, 2^code beats |
| cfg_ilv | input | 1 | Burst order: 0 sequential wrap, 1 interleaved |
| cfg_single_wr | input | 1 | Writes store a single beat |
| dqm | input | LANES | Per-byte-lane mask |
| wdata | input | LANES*LANE_W | Write data, lane l in bits 8l+7..8l |
| rdata | output | LANES*LANE_W | Read data, zero in lanes not enabled |
| rd_oe | output | LANES | Per-lane read output enable |

## Verification
If the burst counter or start column is stored wrongly, the read data shows a word from the wrong column. This appears exactly CL cycles after the beat is issued, and all later beats of the burst are affected too. If the active flag stays set after a stop or after the last beat, `rd_oe` stays high beyond the burst length. This is visible within CL cycles. A fault in the latency or mask delay stages moves the enabled window or the masked slot by one cycle, so a check made at the exact cycle catches it. A write-mask fault only appears once the column is read back. The bench therefore reads back every block it writes.

// File: rtl/sdr_pkg.sv
package sdr_pkg;

    typedef enum logic [1:0] {
        OP_NOP  = 2'd0,
        OP_RD   = 2'd1,
        OP_WR   = 2'd2,
        OP_STOP = 2'd3
    } col_op_e;

    localparam int MIN_CL     = 2;
    localparam int MAX_CL     = 3;
    localparam int BEAT_IDX_W = 3;   // up to 8 beats

    typedef struct packed {
        logic                  act;
        logic                  wr;
        logic                  ilv;
        logic [1:0]            code;
        logic [BEAT_IDX_W-1:0] idx;
    } burst_ctx_t;

    function automatic logic [BEAT_IDX_W-1:0] last_beat(input logic [1:0] code);
        return BEAT_IDX_W'((4'd1 << code) - 4'd1);
    endfunction

    // Low column bits for a beat; upper bits never change inside a burst.
    function automatic logic [BEAT_IDX_W-1:0] burst_low(
        input logic [BEAT_IDX_W-1:0] start,
        input logic [BEAT_IDX_W-1:0] idx,
        input logic [1:0]            code,
        input logic                  ilv
    );
        logic [BEAT_IDX_W-1:0] m;
        logic [BEAT_IDX_W-1:0] sum;
        m   = last_beat(code);
        sum = start + idx;
        if (ilv)
            return start ^ idx;
        return (start & ~m) | (sum & m);
    endfunction

endpackage

// File: rtl/sdr_burst_seq.sv
module sdr_burst_seq
    import sdr_pkg::*;
#(
    parameter int COL_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  col_op_e          op,
    input  logic [COL_W-1:0] col,
    input  logic [1:0]       cfg_blen,
    input  logic             cfg_ilv,
    input  logic             cfg_single_wr,
    output logic             beat_vld,
    output logic             beat_wr,
    output logic [COL_W-1:0] beat_addr,
    output logic             burst_act
);
    localparam int HI_W = COL_W - BEAT_IDX_W;

    burst_ctx_t       ctx_q, ctx_n, cur;
    logic [COL_W-1:0] base_q, cur_base;
    logic [BEAT_IDX_W-1:0] low;

    // Beat served on this edge: a new command wins over the running burst.
    always_comb begin
        cur      = ctx_q;
        cur_base = base_q;
        if (op == OP_RD || op == OP_WR) begin
            cur.act  = 1'b1;
            cur.wr   = (op == OP_WR);
            cur.ilv  = cfg_ilv;
            cur.code = (op == OP_WR && cfg_single_wr) ? 2'd0 : cfg_blen;
            cur.idx  = '0;
            cur_base = col;
        end else if (op == OP_STOP) begin
            cur.act = 1'b0;
        end
    end

    assign low       = burst_low(cur_base[BEAT_IDX_W-1:0], cur.idx, cur.code, cur.ilv);
    assign beat_vld  = cur.act;
    assign beat_wr   = cur.wr;
    assign beat_addr = {cur_base[COL_W-1 -: HI_W], low};
    assign burst_act = ctx_q.act;

    always_comb begin
        ctx_n = cur;
        if (cur.act) begin
            if (cur.idx == last_beat(cur.code))
                ctx_n.act = 1'b0;
            else
                ctx_n.idx = cur.idx + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctx_q  <= '0;
            base_q <= '0;
        end else begin
            ctx_q  <= ctx_n;
            base_q <= cur_base;
        end
    end

endmodule

// File: rtl/sdr_col_store.sv
module sdr_col_store #(
    parameter int COL_W  = 6,
    parameter int LANES  = 2,
    parameter int LANE_W = 8
) (
    input  logic                    clk,
    input  logic                    we,
    input  logic [COL_W-1:0]        addr,
    input  logic [LANES-1:0]        lane_mask,
    input  logic [LANES*LANE_W-1:0] wdata,
    output logic [LANES*LANE_W-1:0] rdata
);
    localparam int DEPTH = 1 << COL_W;

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic [LANE_W-1:0] arr [DEPTH];

        always_ff @(posedge clk) begin
            if (we && !lane_mask[l])
                arr[addr] <= wdata[l*LANE_W +: LANE_W];
        end

        assign rdata[l*LANE_W +: LANE_W] = arr[addr];
    end

endmodule

// File: rtl/sdr_rd_pipe.sv
module sdr_rd_pipe
    import sdr_pkg::*;
#(
    parameter int LANES  = 2,
    parameter int LANE_W = 8
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    in_vld,
    input  logic [LANES*LANE_W-1:0] in_data,
    input  logic                    cas3,
    input  logic [LANES-1:0]        dqm,
    output logic                    out_vld,
    output logic [LANES-1:0]        out_oe,
    output logic [LANES*LANE_W-1:0] out_data
);
    localparam int DW = LANES * LANE_W;

    logic [MAX_CL-1:0] vld_q;
    logic [DW-1:0]     dat_q [MAX_CL];
    logic [LANES-1:0]  msk_q1, msk_q2;
    logic [DW-1:0]     sel_data;

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q  <= '0;
            msk_q1 <= '0;
            msk_q2 <= '0;
        end else begin
            vld_q  <= {vld_q[MAX_CL-2:0], in_vld};
            msk_q1 <= dqm;
            msk_q2 <= msk_q1;
        end
    end

    always_ff @(posedge clk) begin
        dat_q[0] <= in_data;
        for (int i = 1; i < MAX_CL; i++)
            dat_q[i] <= dat_q[i-1];
    end

    assign out_vld  = cas3 ? vld_q[MAX_CL-1] : vld_q[MIN_CL-1];
    assign sel_data = cas3 ? dat_q[MAX_CL-1] : dat_q[MIN_CL-1];

    for (genvar l = 0; l < LANES; l++) begin : g_out
        assign out_oe[l] = out_vld & ~msk_q2[l];
        assign out_data[l*LANE_W +: LANE_W] =
            out_oe[l] ? sel_data[l*LANE_W +: LANE_W] : '0;
    end

endmodule

// File: rtl/sdr_burst_path.sv
module sdr_burst_path
    import sdr_pkg::*;
#(
    parameter int COL_W  = 6,
    parameter int LANES  = 2,
    parameter int LANE_W = 8
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [1:0]              cmd_op,
    input  logic [COL_W-1:0]        cmd_col,
    input  logic                    cfg_cas3,
    input  logic [1:0]              cfg_blen,
    input  logic                    cfg_ilv,
    input  logic                    cfg_single_wr,
    input  logic [LANES-1:0]        dqm,
    input  logic [LANES*LANE_W-1:0] wdata,
    output logic [LANES*LANE_W-1:0] rdata,
    output logic [LANES-1:0]        rd_oe
);
    localparam int DW = LANES * LANE_W;

    col_op_e          op;
    logic             beat_vld, beat_wr, burst_act, rd_vld;
    logic [COL_W-1:0] beat_addr;
    logic [DW-1:0]    core_rd;

    assign op = col_op_e'(cmd_op);

    sdr_burst_seq #(.COL_W(COL_W)) u_seq (
        .clk           (clk),
        .rst           (rst),
        .op            (op),
        .col           (cmd_col),
        .cfg_blen      (cfg_blen),
        .cfg_ilv       (cfg_ilv),
        .cfg_single_wr (cfg_single_wr),
        .beat_vld      (beat_vld),
        .beat_wr       (beat_wr),
        .beat_addr     (beat_addr),
        .burst_act     (burst_act)
    );

    sdr_col_store #(.COL_W(COL_W), .LANES(LANES), .LANE_W(LANE_W)) u_store (
        .clk       (clk),
        .we        (beat_vld & beat_wr),
        .addr      (beat_addr),
        .lane_mask (dqm),
        .wdata     (wdata),
        .rdata     (core_rd)
    );

    sdr_rd_pipe #(.LANES(LANES), .LANE_W(LANE_W)) u_pipe (
        .clk      (clk),
        .rst      (rst),
        .in_vld   (beat_vld & ~beat_wr),
        .in_data  (core_rd),
        .cas3     (cfg_cas3),
        .dqm      (dqm),
        .out_vld  (rd_vld),
        .out_oe   (rd_oe),
        .out_data (rdata)
    );

endmodule

// File: rtl/sdr_burst_path_chk.sv
module sdr_burst_path_chk #(
    parameter int LANES = 2
) (
    input logic             clk,
    input logic             rst,
    input logic [1:0]       cmd_op,
    input logic             cfg_cas3,
    input logic [1:0]       cfg_blen,
    input logic             cfg_single_wr,
    input logic [LANES-1:0] dqm,
    input logic [LANES-1:0] rd_oe,
    input logic             rd_vld,
    input logic             beat_vld,
    input logic             beat_wr,
    input logic             burst_act
);
    logic [1:0] since;

    always_ff @(posedge clk) begin
        if (rst)
            since <= '0;
        else if (since != 2'd3)
            since <= since + 2'd1;
    end

    a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (rd_oe == '0));

    a_r2_latency_two: assert property (@(posedge clk) disable iff (rst)
        (beat_vld && !beat_wr && !cfg_cas3) |-> ##2 rd_vld);

    a_r2_latency_three: assert property (@(posedge clk) disable iff (rst)
        (beat_vld && !beat_wr && cfg_cas3) |-> ##3 rd_vld);

    a_r3_single_beat_read: assert property (@(posedge clk) disable iff (rst)
        (cmd_op == 2'd1 && cfg_blen == 2'd0) |=> !burst_act);

    a_r7_read_mask_slot: assert property (@(posedge clk) disable iff (rst)
        (since == 2'd3) |-> (($past(dqm, 2) & rd_oe) == '0));

    a_r9_stop_ends_burst: assert property (@(posedge clk) disable iff (rst)
        (cmd_op == 2'd3) |=> !burst_act);

    a_r10_single_write: assert property (@(posedge clk) disable iff (rst)
        (cmd_op == 2'd2 && cfg_single_wr) |=> !burst_act);

    a_r11_oe_needs_beat: assert property (@(posedge clk) disable iff (rst)
        !rd_vld |-> (rd_oe == '0));

    a_r11_vld_has_source: assert property (@(posedge clk) disable iff (rst)
        (since == 2'd3 && rd_vld && !cfg_cas3) |-> $past(beat_vld && !beat_wr, 2));

endmodule

bind sdr_burst_path sdr_burst_path_chk #(.LANES(LANES)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .cmd_op        (cmd_op),
    .cfg_cas3      (cfg_cas3),
    .cfg_blen      (cfg_blen),
    .cfg_single_wr (cfg_single_wr),
    .dqm           (dqm),
    .rd_oe         (rd_oe),
    .rd_vld        (rd_vld),
    .beat_vld      (beat_vld),
    .beat_wr       (beat_wr),
    .burst_act     (burst_act)
);

// File: tb/sdr_burst_path_test.sv
module sdr_burst_path_test;
    localparam int CLK_PERIOD = 10;
    localparam int COL_W      = 6;
    localparam int LANES      = 2;
    localparam int LANE_W     = 8;
    localparam int DW         = LANES * LANE_W;
    localparam int DEPTH      = 1 << COL_W;
    localparam int WATCHDOG   = 150000;
    localparam logic [1:0] C_NOP = 2'd0, C_RD = 2'd1, C_WR = 2'd2, C_STOP = 2'd3;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [1:0]       cmd_op = C_NOP;
    logic [COL_W-1:0] cmd_col = '0;
    logic             cfg_cas3 = 1'b0;
    logic [1:0]       cfg_blen = 2'd0;
    logic             cfg_ilv = 1'b0;
    logic             cfg_single_wr = 1'b0;
    logic [LANES-1:0] dqm = '0;
    logic [DW-1:0]    wdata = '0;
    logic [DW-1:0]    rdata;
    logic [LANES-1:0] rd_oe;

    int checks = 0;
    int errs   = 0;

    logic [DW-1:0]    ref_mem [DEPTH];
    logic [LANES-1:0] rd_mask [32];

    always #(CLK_PERIOD/2) clk = ~clk;

    sdr_burst_path #(.COL_W(COL_W), .LANES(LANES), .LANE_W(LANE_W)) uut (
        .clk(clk), .rst(rst), .cmd_op(cmd_op), .cmd_col(cmd_col),
        .cfg_cas3(cfg_cas3), .cfg_blen(cfg_blen), .cfg_ilv(cfg_ilv),
        .cfg_single_wr(cfg_single_wr), .dqm(dqm), .wdata(wdata),
        .rdata(rdata), .rd_oe(rd_oe)
    );

    function automatic int exp_col(int start, int i, int code, bit ilv);
        int n = 1 << code;
        if (ilv) return start ^ i;
        return (start & ~(n - 1)) | ((start + i) & (n - 1));
    endfunction

    task automatic check(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
        end
    endtask

    task automatic clear_mask();
        for (int i = 0; i < 32; i++) rd_mask[i] = '0;
    endtask

    // Write burst starting now; always drives 2^code data cycles.
    task automatic write_seq(int col, int code, bit ilv, bit single, bit rnd_mask);
        int n = 1 << code;
        int n_store = single ? 1 : n;
        @(negedge clk);
        cfg_blen = 2'(code); cfg_ilv = ilv; cfg_single_wr = single;
        for (int i = 0; i < n; i++) begin
            logic [DW-1:0]    d = DW'($urandom);
            logic [LANES-1:0] m = rnd_mask ? LANES'($urandom) : '0;
            if (i > 0) @(negedge clk);
            cmd_op  = (i == 0) ? C_WR : C_NOP;
            cmd_col = COL_W'(col);
            wdata   = d;
            dqm     = m;
            if (i < n_store) begin
                int a = exp_col(col, i, code, ilv);
                for (int l = 0; l < LANES; l++)
                    if (!m[l]) ref_mem[a][l*LANE_W +: LANE_W] = d[l*LANE_W +: LANE_W];
            end
        end
        @(negedge clk);
        cmd_op = C_NOP; dqm = '0;
    endtask

    // Read burst with optional interrupting read at edge intr_at or stop at edge stop_at.
    task automatic read_seq(int col, int cl, int code, bit ilv, int intr_at, int col2,
                            int stop_at, string req);
        bit vld_e [32];
        int adr_e [32];
        int n = 1 << code;
        for (int e = 0; e < 32; e++) begin
            vld_e[e] = 1'b0; adr_e[e] = 0;
            if (stop_at > 0 && e >= stop_at) begin
                vld_e[e] = 1'b0;
            end else if (intr_at > 0 && e >= intr_at) begin
                vld_e[e] = (e - intr_at) < n;
                adr_e[e] = exp_col(col2, e - intr_at, code, ilv);
            end else begin
                vld_e[e] = e < n;
                adr_e[e] = exp_col(col, e, code, ilv);
            end
        end
        @(negedge clk);
        cfg_cas3 = (cl == 3); cfg_blen = 2'(code); cfg_ilv = ilv;
        cmd_op = C_RD; cmd_col = COL_W'(col); dqm = rd_mask[0];
        for (int k = 1; k <= cl + 20; k++) begin
            int e = k - cl;
            logic [LANES-1:0] eoe = '0;
            logic [DW-1:0]    edat = '0;
            @(negedge clk);
            if (e >= 0 && vld_e[e]) begin
                eoe = ~((k >= 2) ? rd_mask[k-2] : '0);
                for (int l = 0; l < LANES; l++)
                    if (eoe[l]) edat[l*LANE_W +: LANE_W] = ref_mem[adr_e[e]][l*LANE_W +: LANE_W];
            end
            check(rd_oe == eoe, req, $sformatf("oe cycle %0d", k), 32'(rd_oe), 32'(eoe));
            check(rdata == edat, req, $sformatf("data cycle %0d", k), 32'(rdata), 32'(edat));
            cmd_op  = (k == intr_at) ? C_RD : ((k == stop_at) ? C_STOP : C_NOP);
            cmd_col = COL_W'(col2);
            dqm     = rd_mask[k];
        end
        cmd_op = C_NOP; dqm = '0;
        clear_mask();
    endtask

    initial begin
        void'($urandom(32'd2024));
        clear_mask();
        // R1: reset state
        repeat (3) @(negedge clk);
        check(rd_oe == '0 && rdata == '0, "R1", "during reset", 32'(rd_oe), 0);
        rst = 1'b0;
        @(negedge clk);
        check(rd_oe == '0 && rdata == '0, "R1", "after release", 32'(rd_oe), 0);

        // Fill the array with sequential BL8 writes.
        for (int b = 0; b < DEPTH; b += 8) write_seq(b, 3, 0, 0, 0);

        // R2, R3, R4: latencies, lengths, sequential wrap
        read_seq(13, 2, 3, 0, 0, 0, 0, "R2");
        read_seq(6, 3, 2, 0, 0, 0, 0, "R4");
        read_seq(3, 2, 1, 0, 0, 0, 0, "R3");
        read_seq(42, 3, 0, 0, 0, 0, 0, "R3");
        // R5: interleaved
        read_seq(13, 3, 3, 1, 0, 0, 0, "R5");
        read_seq(5, 2, 2, 1, 0, 0, 0, "R5");
        // R6: write mask same edge
        write_seq(20, 1, 0, 0, 1);
        write_seq(50, 2, 1, 0, 1);
        read_seq(20, 2, 1, 0, 0, 0, 0, "R6");
        read_seq(48, 3, 2, 0, 0, 0, 0, "R6");
        // R7: read mask two cycles later
        rd_mask[3] = 2'b10; rd_mask[4] = 2'b11;
        read_seq(0, 3, 3, 0, 0, 0, 0, "R7");
        rd_mask[1] = 2'b01; rd_mask[0] = 2'b10;
        read_seq(24, 2, 2, 0, 0, 0, 0, "R7");
        // R8: interruption by a new read
        read_seq(0, 2, 3, 0, 2, 40, 0, "R8");
        read_seq(9, 3, 3, 1, 3, 30, 0, "R8");
        // R9: burst stop
        read_seq(16, 3, 3, 0, 0, 0, 3, "R9");
        read_seq(34, 2, 2, 0, 0, 0, 1, "R9");
        // R10: single-beat write mode, reads keep burst length
        write_seq(33, 3, 0, 1, 0);
        read_seq(32, 2, 3, 0, 0, 0, 0, "R10");
        cfg_single_wr = 1'b0;

        // Random mix
        for (int it = 0; it < 60; it++) begin
            int col  = int'($urandom % DEPTH);
            int code = int'($urandom % 4);
            bit ilv  = 1'($urandom);
            if ($urandom % 3 == 0) begin
                write_seq(col, code, ilv, 0, 1);
            end else begin
                int cl = ($urandom % 2 == 0) ? 2 : 3;
                int sel = int'($urandom % 4);
                for (int k = 0; k < 12; k++)
                    if ($urandom % 5 == 0) rd_mask[k] = LANES'($urandom);
                if (sel == 0)
                    read_seq(col, cl, code, ilv, 1 + int'($urandom % 6), int'($urandom % DEPTH), 0, "R8");
                else if (sel == 1)
                    read_seq(col, cl, code, ilv, 0, 0, 1 + int'($urandom % 6), "R9");
                else
                    read_seq(col, cl, code, ilv, 0, 0, 0, "R3");
            end
        end

        $display("CHECKS %0d ERRORS %0d", checks, errs);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        errs++;
        $display("FAIL watchdog all-requirements act=timeout exp=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errs);
        $finish;
    end

endmodule